// File: doc/BRIEF.md
# Trigger and Qualification Condition Evaluator

This block watches a probed bus and, every clock cycle, decides two things: whether a capture should start now (the trigger) and whether the current sample is worth recording (qualification). A set of comparator slots each look at a masked field of the probe. A field can be a whole bus or, with a one-hot mask, a single bit. Each slot applies one of six unsigned tests against operands held in configuration registers. The slot results feed two separate equations, one for the trigger and one for qualification. Each equation has an AND term over one chosen set of slots and an OR term over another set, joined by a selectable mix mode.

Every operand, mask, operator, enable and slot selection is an ordinary input, so software can rewrite a condition between captures without rebuilding the design. Only probe bits listed in a build-time source mask can reach the comparators. The qualification level is registered once, so it lines up with a one-stage delayed copy of the sample data. The trigger is a single-cycle pulse, produced from that same register stage, when the trigger condition goes from false to true.

Top module: `trig_qual_eval`

## Requirements
- R1: A slot's field is `probe_i & SRC_MASK & slot mask`. Probe bits outside the build-time parameter `SRC_MASK` never change either output.
- R2: Operator code 0 is true when the field equals `lo`. Operator code 1 is true when the field differs from `lo`.
- R3: Operator code 2 is true when the field is below `lo`. Operator code 3 is true when the field is above `lo`. Both comparisons are unsigned.
- R4: Operator code 4 is true when `lo <= field <= hi`, with both bounds included. Operator code 5 is its exact complement. When `lo > hi`, code 4 is never true and code 5 is always true.
- R5: Operator codes 6 and 7 are reserved and make the slot false.
- R6: A slot that is disabled, or not selected for a term, counts as true in that AND term and as false in that OR term. An AND term with no active slots is true. An OR term with no active slots is false.
- R7: The mix mode sets the equation result: 0 = AND term only, 1 = OR term only, 2 = AND term OR OR term, 3 = AND term AND OR term.
- R8: `qual_o` equals the qualification condition as it stood at the previous rising clock edge.
- R9: `trig_o` is high for exactly one cycle, in the cycle after the trigger condition changes from false to true. A condition that is already true at the first edge after reset counts as a rise.
- R10: The trigger and qualification equations are set independently. A configuration change takes effect with the same one-cycle latency as a probe change.
- R11: While reset is asserted, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| probe_i | input | FIELD_W | Probed signals |
| slot_en_i | input | NUM_SLOTS | Per-slot enable |
| slot_op_i | input | 3*NUM_SLOTS | Per-slot operator code |
| slot_mask_i | input | FIELD_W*NUM_SLOTS | Per-slot field mask |
| slot_lo_i | input | FIELD_W*NUM_SLOTS | Per-slot compare value or lower bound |
| slot_hi_i | input | FIELD_W*NUM_SLOTS | Per-slot upper bound |
| trig_and_sel_i | input | NUM_SLOTS | Slots in the trigger AND term |
| trig_or_sel_i | input | NUM_SLOTS | Slots in the trigger OR term |
| trig_mode_i | input | 2 | Trigger mix mode |
| qual_and_sel_i | input | NUM_SLOTS | Slots in the qualification AND term |
| qual_or_sel_i | input | NUM_SLOTS | Slots in the qualification OR term |
| qual_mode_i | input | 2 | Qualification mix mode |
| trig_o | output | 1 | One-cycle trigger pulse |
| qual_o | output | 1 | Registered qualification level |

## Verification
The bench applies every operator code to every 4-bit field value, first with a normal window and then with an inverted window (`lo > hi`). This exposes an exclusive bound, a signed comparison, or a reserved code that accidentally passes. It then sweeps every mix mode against every enable and hit pattern over four slots. A design that treated a disabled slot as false in the AND term, or as true in the OR term, would give the wrong qualification level there. Trigger sequences with held conditions, a change made only through configuration, and a condition already true when reset is released all catch a level trigger in place of a pulse, or a missed first rise. Finally, a probe bit outside the source mask is toggled and must have no effect.

// File: rtl/tqc_pkg.sv
package tqc_pkg;

  localparam int unsigned CMP_MAX_W = 64;
  typedef logic [CMP_MAX_W-1:0] cmp_word_t;

  typedef enum logic [2:0] {
    OP_EQ   = 3'd0,
    OP_NE   = 3'd1,
    OP_LT   = 3'd2,
    OP_GT   = 3'd3,
    OP_IN   = 3'd4,
    OP_OUT  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } cmp_op_e;

  typedef enum logic [1:0] {
    MIX_AND  = 2'd0,
    MIX_OR   = 2'd1,
    MIX_ANY  = 2'd2,
    MIX_BOTH = 2'd3
  } mix_e;

  // Unsigned test of a field against its operands.
  function automatic logic cmp_eval(cmp_op_e op, cmp_word_t f, cmp_word_t lo, cmp_word_t hi);
    logic in_win;
    logic res;
    in_win = (f >= lo) && (f <= hi);
    case (op)
      OP_EQ:   res = (f == lo);
      OP_NE:   res = (f != lo);
      OP_LT:   res = (f < lo);
      OP_GT:   res = (f > lo);
      OP_IN:   res = in_win;
      OP_OUT:  res = !in_win;
      default: res = 1'b0;
    endcase
    return res;
  endfunction

  // Join an AND term and an OR term according to the mix mode.
  function automatic logic mix_eval(mix_e m, logic and_t, logic or_t);
    logic res;
    case (m)
      MIX_AND:  res = and_t;
      MIX_OR:   res = or_t;
      MIX_ANY:  res = and_t | or_t;
      default:  res = and_t & or_t;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/tqc_slot.sv
module tqc_slot
  import tqc_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] field_i,
  input  logic [2:0]   op_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  output logic         hit_o
);

  cmp_op_e   op_w;
  cmp_word_t field_ext;
  cmp_word_t lo_ext;
  cmp_word_t hi_ext;

  always_comb begin
    op_w      = cmp_op_e'(op_i);
    field_ext = CMP_MAX_W'(field_i);
    lo_ext    = CMP_MAX_W'(lo_i);
    hi_ext    = CMP_MAX_W'(hi_i);
    hit_o     = cmp_eval(op_w, field_ext, lo_ext, hi_ext);
  end

endmodule

// File: rtl/tqc_combine.sv
module tqc_combine
  import tqc_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] hit_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] and_sel_i,
  input  logic [N-1:0] or_sel_i,
  input  logic [1:0]   mode_i,
  output logic         and_term_o,
  output logic         or_term_o,
  output logic         cond_o
);

  logic [N-1:0] and_in;
  logic [N-1:0] or_in;

  // Inactive slots are neutral: true for AND, false for OR.
  always_comb begin
    and_in     = ~(and_sel_i & en_i) | hit_i;
    or_in      = or_sel_i & en_i & hit_i;
    and_term_o = &and_in;
    or_term_o  = |or_in;
    cond_o     = mix_eval(mix_e'(mode_i), and_term_o, or_term_o);
  end

endmodule

// File: rtl/trig_qual_eval.sv
module trig_qual_eval #(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned FIELD_W   = 32,
  parameter logic [FIELD_W-1:0] SRC_MASK = '1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [FIELD_W-1:0]            probe_i,
  input  logic [NUM_SLOTS-1:0]          slot_en_i,
  input  logic [3*NUM_SLOTS-1:0]        slot_op_i,
  input  logic [FIELD_W*NUM_SLOTS-1:0]  slot_mask_i,
  input  logic [FIELD_W*NUM_SLOTS-1:0]  slot_lo_i,
  input  logic [FIELD_W*NUM_SLOTS-1:0]  slot_hi_i,
  input  logic [NUM_SLOTS-1:0]          trig_and_sel_i,
  input  logic [NUM_SLOTS-1:0]          trig_or_sel_i,
  input  logic [1:0]                    trig_mode_i,
  input  logic [NUM_SLOTS-1:0]          qual_and_sel_i,
  input  logic [NUM_SLOTS-1:0]          qual_or_sel_i,
  input  logic [1:0]                    qual_mode_i,
  output logic                          trig_o,
  output logic                          qual_o
);

  localparam int unsigned OP_W = 3;

  // Only probe bits marked as sources at build time reach the slots.
  logic [FIELD_W-1:0]   src_probe_w;
  logic [NUM_SLOTS-1:0] slot_hit_w;
  logic                 trig_and_w, trig_or_w, cond_trig_w;
  logic                 qual_and_w, qual_or_w, cond_qual_w;
  logic                 cond_trig_q;

  assign src_probe_w = probe_i & SRC_MASK;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic [FIELD_W-1:0] field_w;
    assign field_w = src_probe_w & slot_mask_i[i*FIELD_W +: FIELD_W];
    tqc_slot #(.W(FIELD_W)) u_slot (
      .field_i (field_w),
      .op_i    (slot_op_i[i*OP_W +: OP_W]),
      .lo_i    (slot_lo_i[i*FIELD_W +: FIELD_W]),
      .hi_i    (slot_hi_i[i*FIELD_W +: FIELD_W]),
      .hit_o   (slot_hit_w[i])
    );
  end

  tqc_combine #(.N(NUM_SLOTS)) u_trig_eq (
    .hit_i      (slot_hit_w),
    .en_i       (slot_en_i),
    .and_sel_i  (trig_and_sel_i),
    .or_sel_i   (trig_or_sel_i),
    .mode_i     (trig_mode_i),
    .and_term_o (trig_and_w),
    .or_term_o  (trig_or_w),
    .cond_o     (cond_trig_w)
  );

  tqc_combine #(.N(NUM_SLOTS)) u_qual_eq (
    .hit_i      (slot_hit_w),
    .en_i       (slot_en_i),
    .and_sel_i  (qual_and_sel_i),
    .or_sel_i   (qual_or_sel_i),
    .mode_i     (qual_mode_i),
    .and_term_o (qual_and_w),
    .or_term_o  (qual_or_w),
    .cond_o     (cond_qual_w)
  );

  // One register stage: qualification level and rising-edge trigger.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_trig_q <= 1'b0;
      trig_o      <= 1'b0;
      qual_o      <= 1'b0;
    end else begin
      cond_trig_q <= cond_trig_w;
      trig_o      <= cond_trig_w & ~cond_trig_q;
      qual_o      <= cond_qual_w;
    end
  end

endmodule

// File: rtl/tqc_checker.sv
module tqc_checker #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic [N-1:0]   slot_en_i,
  input logic [3*N-1:0] slot_op_i,
  input logic [W*N-1:0] slot_lo_i,
  input logic [W*N-1:0] slot_hi_i,
  input logic [N-1:0]   slot_hit_w,
  input logic [1:0]     trig_mode_i,
  input logic           cond_trig_w,
  input logic           cond_qual_w,
  input logic           trig_o,
  input logic           qual_o
);

  // Counts edges seen out of reset, saturating, so $past never reaches into reset.
  logic [1:0] live_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_cnt <= 2'd0;
    else if (live_cnt != 2'd3) live_cnt <= live_cnt + 2'd1;
  end

  assert_trig_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |=> !trig_o);

  assert_trig_on_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (live_cnt >= 2'd2) |-> (trig_o == ($past(cond_trig_w) && !$past(cond_trig_w, 2))));

  assert_qual_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (live_cnt >= 2'd1) |-> (qual_o == $past(cond_qual_w)));

  assert_empty_and_true_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((slot_en_i == '0) && (trig_mode_i == 2'd0)) |-> cond_trig_w);

  assert_empty_or_false_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((slot_en_i == '0) && (trig_mode_i == 2'd1)) |-> !cond_trig_w);

  for (genvar i = 0; i < N; i++) begin : g_slot_chk
    assert_reserved_false_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_op_i[3*i +: 3] >= 3'd6) |-> !slot_hit_w[i]);

    assert_range_bounds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((slot_op_i[3*i +: 3] == 3'd4) && slot_hit_w[i]) |->
        (slot_lo_i[W*i +: W] <= slot_hi_i[W*i +: W]));

    assert_out_inverted_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((slot_op_i[3*i +: 3] == 3'd5) && (slot_lo_i[W*i +: W] > slot_hi_i[W*i +: W]))
        |-> slot_hit_w[i]);
  end

endmodule

bind trig_qual_eval tqc_checker #(.N(NUM_SLOTS), .W(FIELD_W)) u_tqc_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .slot_en_i   (slot_en_i),
  .slot_op_i   (slot_op_i),
  .slot_lo_i   (slot_lo_i),
  .slot_hi_i   (slot_hi_i),
  .slot_hit_w  (slot_hit_w),
  .trig_mode_i (trig_mode_i),
  .cond_trig_w (cond_trig_w),
  .cond_qual_w (cond_qual_w),
  .trig_o      (trig_o),
  .qual_o      (qual_o)
);

// File: tb/trig_qual_eval_bench.sv
`timescale 1ns/1ps
module trig_qual_eval_bench;

  localparam int N = 4;
  localparam int W = 32;
  localparam logic [W-1:0] SRC = 32'h0FFF_FFFF;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [W-1:0]   probe = '0;
  logic [N-1:0]   en = '0;
  logic [3*N-1:0] op = '0;
  logic [W*N-1:0] mask = '0, lo = '0, hi = '0;
  logic [N-1:0]   t_and = '0, t_or = '0, q_and = '0, q_or = '0;
  logic [1:0]     t_mode = 2'd0, q_mode = 2'd0;
  logic           trig, qual;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  trig_qual_eval #(.NUM_SLOTS(N), .FIELD_W(W), .SRC_MASK(SRC)) u_trig_qual_eval (
    .clk(clk), .rst_n(rst_n), .probe_i(probe), .slot_en_i(en), .slot_op_i(op),
    .slot_mask_i(mask), .slot_lo_i(lo), .slot_hi_i(hi),
    .trig_and_sel_i(t_and), .trig_or_sel_i(t_or), .trig_mode_i(t_mode),
    .qual_and_sel_i(q_and), .qual_or_sel_i(q_or), .qual_mode_i(q_mode),
    .trig_o(trig), .qual_o(qual)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_slot(input int i, input logic [2:0] o, input logic [W-1:0] m,
                          input logic [W-1:0] l, input logic [W-1:0] h);
    op[3*i +: 3]   = o;
    mask[W*i +: W] = m;
    lo[W*i +: W]   = l;
    hi[W*i +: W]   = h;
  endtask

  // Bench's own reading of the operator table (R2-R5).
  function automatic bit model_op(int o, longint f, longint l, longint h);
    bit below = (f < l);
    bit above = (f > h);
    if (o == 0) return f == l;
    if (o == 1) return !(f == l);
    if (o == 2) return below;
    if (o == 3) return (f > l);
    if (o == 4) return !below && !above;
    if (o == 5) return below || above;
    return 0;
  endfunction

  function automatic string op_tag(int o);
    if (o < 2) return "R2";
    if (o < 4) return "R3";
    if (o < 6) return "R4";
    return "R5";
  endfunction

  initial begin
    #200us;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R11: outputs low during reset
    probe = '1;
    en = 4'b1111;
    t_mode = 2'd0;
    q_mode = 2'd0;
    step();
    chk(trig, 1'b0, "R11 trig in reset");
    chk(qual, 1'b0, "R11 qual in reset");
    rst_n = 1'b1;
    step();

    // Operator sweep on slot 0, qualification as OR of slot 0
    en = 4'b0001;
    q_and = '0;
    q_or = 4'b0001;
    q_mode = 2'd1;
    for (int o = 0; o < 8; o++) begin
      for (int v = 0; v < 16; v++) begin
        probe = 32'(v);
        set_slot(0, 3'(o), 32'hF, 32'd5, 32'd10);
        step();
        chk(qual, model_op(o, v, 5, 10), op_tag(o));
      end
    end
    // R4: inverted window lo > hi
    for (int o = 4; o < 6; o++) begin
      for (int v = 0; v < 16; v++) begin
        probe = 32'(v);
        set_slot(0, 3'(o), 32'hF, 32'd10, 32'd5);
        step();
        chk(qual, (o == 5), "R4 inverted window");
      end
    end

    // R1: bit 31 is outside the source mask and never reaches a slot
    set_slot(0, 3'd0, 32'h8000_0000, 32'h0, 32'h0);
    probe = 32'h8000_0000;
    step();
    chk(qual, 1'b1, "R1 masked source bit ignored");
    set_slot(0, 3'd0, 32'h8000_0000, 32'h8000_0000, 32'h0);
    step();
    chk(qual, 1'b0, "R1 masked source bit never matches");

    // R6, R7: every mode x enable x hit pattern over four slots
    for (int i = 0; i < N; i++)
      set_slot(i, 3'd3, 32'hF << (4 * i), 32'h7 << (4 * i), 32'h0);
    q_and = 4'b0111;
    q_or  = 4'b1110;
    for (int md = 0; md < 4; md++) begin
      for (int e = 0; e < 16; e++) begin
        for (int h = 0; h < 16; h++) begin
          bit at;
          bit ot;
          bit ex;
          q_mode = 2'(md);
          en = 4'(e);
          probe = '0;
          for (int i = 0; i < N; i++)
            if (h[i]) probe = probe | (32'h8 << (4 * i));
          at = 1;
          ot = 0;
          for (int i = 0; i < N; i++) begin
            if (q_and[i] && e[i] && !h[i]) at = 0;
            if (q_or[i] && e[i] && h[i]) ot = 1;
          end
          case (md)
            0: ex = at;
            1: ex = ot;
            2: ex = at || ot;
            default: ex = at && ot;
          endcase
          step();
          chk(qual, ex, "R6,R7 combine");
        end
      end
    end

    // R9, R10: trigger on slot 0 == 1, qualification an empty AND (always true)
    en = 4'b0001;
    set_slot(0, 3'd0, 32'hF, 32'd1, 32'd0);
    t_and = '0;
    t_or = 4'b0001;
    t_mode = 2'd1;
    q_and = '0;
    q_or = '0;
    q_mode = 2'd0;
    probe = '0;
    step();
    chk(trig, 1'b0, "R9 idle");
    chk(qual, 1'b1, "R6,R10 empty AND qualification");
    begin
      logic [7:0] seq = 8'b0010_1110;
      bit prev = 0;
      for (int k = 0; k < 8; k++) begin
        probe = 32'(seq[k]);
        step();
        chk(trig, seq[k] && !prev, "R9 rising pulse");
        chk(qual, 1'b1, "R10 qualification independent");
        prev = seq[k];
      end
    end
    // R10: condition toggled through configuration only
    probe = 32'd1;
    step();
    set_slot(0, 3'd0, 32'hF, 32'd2, 32'd0);
    step();
    chk(trig, 1'b0, "R10 config drops condition");
    set_slot(0, 3'd0, 32'hF, 32'd1, 32'd0);
    step();
    chk(trig, 1'b1, "R10 config re-arms trigger");
    step();
    chk(trig, 1'b0, "R9 pulse ends");

    // R9: condition already true when reset releases
    rst_n = 1'b0;
    step();
    chk(trig, 1'b0, "R11 trig in reset");
    rst_n = 1'b1;
    step();
    chk(trig, 1'b1, "R9 first rise after reset");
    step();
    chk(trig, 1'b0, "R9 held condition no repeat");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule